// File: doc/BRIEF.md
# Micro-frame Interrupt Moderator

This block paces the interrupt line of a host controller so that it is raised at most once per programmed interval. The interval is counted in micro-frames. An 8-bit threshold field selects the interval. A zero code turns pacing off, so an enabled pending event reaches the line at once. The other legal codes are one-hot values, and each value is itself the number of micro-frames in the interval.

A one-cycle tick marks every micro-frame. Hardware raises per-source event bits through set pulses, and software clears them by writing ones. A per-source mask register chooses which events may drive the line. In paced mode the line rises only on the tick that closes an interval, and only if an enabled event is pending then. Once raised, the line stays high until no enabled event remains.

Top module: `mfIrqModerator`

## Requirements
- R1: After reset the threshold reads 08h, all event bits and all mask bits read 0, and the interrupt line is 0.
- R2: A threshold write of 00h, 01h, 02h, 04h, 08h, 10h, 20h or 40h is stored as written and reads back on `thrValue` from the next cycle. Any other written value is stored as 08h.
- R3: With the threshold at 00h, the line is 1 in the cycle after an enabled event bit reads 1, with no tick needed.
- R4: With a threshold code N other than 00h, the interval counter advances once per tick. The N-th tick since the last restart closes the interval. The line rises at the clock edge that samples that tick, if an enabled event was pending before that edge, and at no other edge.
- R5: An event bit whose mask bit is 0 never makes the line rise. The line cannot rise at any edge unless an enabled event bit read 1 in the cycle before.
- R6: A threshold write restarts the interval count at zero. A tick in the same cycle as the write is not counted.
- R7: A 1 on bit i of `statusSet` makes event bit i read 1 from the next cycle. A set and a clear of the same bit in one cycle leave the bit at 1.
- R8: A write with `statusClrWr` high clears every event bit whose data bit is 1 and leaves the others unchanged.
- R9: The line falls at the first edge at which no enabled event bit was 1 in the cycle before. In paced mode it then rises again only at a later interval close.
- R10: While the line is high and some enabled event stays pending, the line stays high whatever the tick and the other event bits do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| thrWrEn | input | 1 | Threshold write strobe |
| thrWrData | input | 8 | Threshold value to write |
| thrValue | output | 8 | Stored threshold code |
| mfTick | input | 1 | One-cycle pulse per micro-frame |
| statusSet | input | NUM_SRC | Per-source event set pulses |
| statusClrWr | input | 1 | Write-one-to-clear strobe for event bits |
| statusClrData | input | NUM_SRC | Event bits to clear |
| enWr | input | 1 | Mask register write strobe |
| enData | input | NUM_SRC | New mask value |
| status | output | NUM_SRC | Event bits |
| enable | output | NUM_SRC | Mask bits |
| irqOut | output | 1 | Paced interrupt line |

## Verification
Every result is due one clock edge after the input that causes it. A threshold, event or mask write shows on its output after the next edge. In immediate mode the line follows one edge after the event bit. In paced mode the line changes at the same edge that samples the closing tick. The bench drives inputs on the falling edge. Its reference model updates on each rising edge from the inputs held there, and every output is compared at the next falling edge. Directed checks at single cycles pin the one-edge delays: before the closing tick, at the closing tick, and after a clear.

// File: rtl/mfIrqPkg.sv
package mfIrqPkg;

  typedef struct packed {
    logic boundary;
    logic immediate;
  } mfStrobe_t;

  function automatic logic isLegalCode(input logic [7:0] code, input int maxInterval);
    logic ok;
    ok = (code == 8'h00);
    for (int i = 0; i < 8; i++) begin
      if ((code == 8'(1 << i)) && ((1 << i) <= maxInterval)) ok = 1'b1;
    end
    return ok;
  endfunction

endpackage

// File: rtl/mfIrqCtrl.sv
module mfIrqCtrl
  import mfIrqPkg::*;
#(
  parameter int THR_W        = 8,
  parameter int MAX_INTERVAL = 64,
  parameter int RESET_CODE   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             thrWrEn,
  input  logic [THR_W-1:0] thrWrData,
  input  logic             mfTick,
  output logic [THR_W-1:0] thrValue,
  output mfStrobe_t        strobe
);

  localparam int CNT_W = (MAX_INTERVAL > 1) ? $clog2(MAX_INTERVAL) : 1;

  logic [THR_W-1:0] thrReg;
  logic [CNT_W-1:0] cnt;
  logic [THR_W-1:0] thrMinus1;
  logic [CNT_W-1:0] lastCount;
  logic             immediate;
  logic             cntAtEnd;
  logic [THR_W-1:0] thrNext;

  assign thrMinus1 = thrReg - THR_W'(1);
  assign lastCount = thrMinus1[CNT_W-1:0];
  assign immediate = (thrReg == '0);
  assign cntAtEnd  = (cnt == lastCount);

  always_comb begin
    if (isLegalCode(thrWrData, MAX_INTERVAL)) thrNext = thrWrData;
    else                                      thrNext = THR_W'(RESET_CODE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrReg <= THR_W'(RESET_CODE);
      cnt    <= '0;
    end else if (thrWrEn) begin
      thrReg <= thrNext;
      cnt    <= '0;
    end else if (mfTick && !immediate) begin
      cnt <= cntAtEnd ? '0 : cnt + CNT_W'(1);
    end
  end

  assign strobe.immediate = immediate;
  assign strobe.boundary  = mfTick && !thrWrEn && !immediate && cntAtEnd;
  assign thrValue         = thrReg;

  assert_thr_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    isLegalCode(thrReg, MAX_INTERVAL));

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    !immediate |-> (cnt <= lastCount));

  assert_write_restarts_R6: assert property (@(posedge clk) disable iff (!rstN)
    thrWrEn |=> (cnt == '0));

endmodule

// File: rtl/mfIrqData.sv
module mfIrqData
  import mfIrqPkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] statusSet,
  input  logic               statusClrWr,
  input  logic [NUM_SRC-1:0] statusClrData,
  input  logic               enWr,
  input  logic [NUM_SRC-1:0] enData,
  input  mfStrobe_t          strobe,
  output logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] enable,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] statusReg;
  logic [NUM_SRC-1:0] enReg;
  logic               irqReg;
  logic               pendingAny;

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusReg[i] <= 1'b0;
      end else if (statusSet[i]) begin
        statusReg[i] <= 1'b1;
      end else if (statusClrWr && statusClrData[i]) begin
        statusReg[i] <= 1'b0;
      end
    end

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rstN)
      (statusClrWr && statusClrData[i] && !statusSet[i]) |=> !statusReg[i]);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
      statusSet[i] |=> statusReg[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)     enReg <= '0;
    else if (enWr) enReg <= enData;
  end

  assign pendingAny = |(statusReg & enReg);

  always_ff @(posedge clk) begin
    if (!rstN) irqReg <= 1'b0;
    else       irqReg <= pendingAny && (strobe.immediate || irqReg || strobe.boundary);
  end

  assign status = statusReg;
  assign enable = enReg;
  assign irqOut = irqReg;

  assert_irq_needs_enabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    !pendingAny |=> !irqOut);

  assert_rise_at_boundary_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && !strobe.immediate && !strobe.boundary) |=> !irqOut);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && pendingAny) |=> irqOut);

  assert_immediate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.immediate && pendingAny) |=> irqOut);

endmodule

// File: rtl/mfIrqModerator.sv
module mfIrqModerator
  import mfIrqPkg::*;
#(
  parameter int NUM_SRC      = 6,
  parameter int MAX_INTERVAL = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               thrWrEn,
  input  logic [7:0]         thrWrData,
  output logic [7:0]         thrValue,
  input  logic               mfTick,
  input  logic [NUM_SRC-1:0] statusSet,
  input  logic               statusClrWr,
  input  logic [NUM_SRC-1:0] statusClrData,
  input  logic               enWr,
  input  logic [NUM_SRC-1:0] enData,
  output logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] enable,
  output logic               irqOut
);

  mfStrobe_t strobe;

  mfIrqCtrl #(
    .THR_W       (8),
    .MAX_INTERVAL(MAX_INTERVAL),
    .RESET_CODE  (8)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .thrWrEn  (thrWrEn),
    .thrWrData(thrWrData),
    .mfTick   (mfTick),
    .thrValue (thrValue),
    .strobe   (strobe)
  );

  mfIrqData #(
    .NUM_SRC(NUM_SRC)
  ) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .statusSet    (statusSet),
    .statusClrWr  (statusClrWr),
    .statusClrData(statusClrData),
    .enWr         (enWr),
    .enData       (enData),
    .strobe       (strobe),
    .status       (status),
    .enable       (enable),
    .irqOut       (irqOut)
  );

endmodule

// File: tb/mfIrqModerator_tb.sv
module mfIrqModerator_tb;

  localparam int NS = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          thrWrEn = 1'b0;
  logic [7:0]    thrWrData = '0;
  logic [7:0]    thrValue;
  logic          mfTick = 1'b0;
  logic [NS-1:0] statusSet = '0;
  logic          statusClrWr = 1'b0;
  logic [NS-1:0] statusClrData = '0;
  logic          enWr = 1'b0;
  logic [NS-1:0] enData = '0;
  logic [NS-1:0] status;
  logic [NS-1:0] enable;
  logic          irqOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mfIrqModerator #(.NUM_SRC(NS), .MAX_INTERVAL(64)) u_dut (
    .clk(clk), .rstN(rstN), .thrWrEn(thrWrEn), .thrWrData(thrWrData),
    .thrValue(thrValue), .mfTick(mfTick), .statusSet(statusSet),
    .statusClrWr(statusClrWr), .statusClrData(statusClrData),
    .enWr(enWr), .enData(enData), .status(status), .enable(enable),
    .irqOut(irqOut)
  );

  // Behavioural reference model
  int         mThr = 8;
  int         mTicks = 0;
  bit [NS-1:0] mStatus = '0;
  bit [NS-1:0] mEnable = '0;
  bit         mIrq = 0;

  function automatic bit legal(input int v);
    return v == 0 || v == 1 || v == 2 || v == 4 || v == 8 || v == 16 || v == 32 || v == 64;
  endfunction

  always @(posedge clk) begin
    bit pend;
    bit closes;
    if (!rstN) begin
      mThr = 8; mTicks = 0; mStatus = '0; mEnable = '0; mIrq = 0;
    end else begin
      pend   = (mStatus & mEnable) != 0;
      closes = 0;
      if (thrWrEn) begin
        mThr   = legal(int'(thrWrData)) ? int'(thrWrData) : 8;
        mTicks = 0;
      end else if (mfTick && mThr != 0) begin
        mTicks = mTicks + 1;
        if (mTicks == mThr) begin
          closes = 1;
          mTicks = 0;
        end
      end
      mIrq = pend && ((mThr == 0 && !thrWrEn) || (thrWrEn && mIrqImmOld()) || mIrq || closes);
      for (int i = 0; i < NS; i++) begin
        if (statusSet[i]) mStatus[i] = 1;
        else if (statusClrWr && statusClrData[i]) mStatus[i] = 0;
      end
      if (enWr) mEnable = enData;
    end
  end

  // threshold in force before a write in the same cycle
  int prevThr = 8;
  function automatic bit mIrqImmOld();
    return prevThr == 0;
  endfunction
  always @(negedge clk) prevThr = mThr;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      check(irqOut == mIrq, "R4 irq model", irqOut, mIrq);
      check(status == mStatus, "R7 status model", status, mStatus);
      check(enable == mEnable, "R5 enable model", enable, mEnable);
      check(int'(thrValue) == mThr, "R2 thr model", thrValue, mThr);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearIns();
    thrWrEn = 0; mfTick = 0; statusSet = '0; statusClrWr = 0; enWr = 0;
  endtask

  task automatic writeThr(input logic [7:0] v);
    thrWrEn = 1; thrWrData = v; @(negedge clk); clearIns();
  endtask

  task automatic tick();
    mfTick = 1; @(negedge clk); clearIns();
  endtask

  task automatic setEv(input logic [NS-1:0] v);
    statusSet = v; @(negedge clk); clearIns();
  endtask

  task automatic clrEv(input logic [NS-1:0] v);
    statusClrWr = 1; statusClrData = v; @(negedge clk); clearIns();
  endtask

  task automatic writeEn(input logic [NS-1:0] v);
    enWr = 1; enData = v; @(negedge clk); clearIns();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(thrValue == 8'h08, "R1 thr", thrValue, 8'h08);
    check(status == '0, "R1 status", status, 0);
    check(enable == '0, "R1 enable", enable, 0);
    check(irqOut == 1'b0, "R1 irq", irqOut, 0);
    rstN = 1;
    @(negedge clk);

    // R2 legal and illegal codes
    writeThr(8'h20); check(thrValue == 8'h20, "R2 legal", thrValue, 8'h20);
    writeThr(8'h03); check(thrValue == 8'h08, "R2 illegal", thrValue, 8'h08);
    writeThr(8'h80); check(thrValue == 8'h08, "R2 illegal high", thrValue, 8'h08);
    writeThr(8'h40); check(thrValue == 8'h40, "R2 legal 40", thrValue, 8'h40);

    // R5 masked event never fires
    writeThr(8'h00);
    setEv(6'b000010);
    idle(3);
    check(irqOut == 1'b0, "R5 masked", irqOut, 0);
    clrEv(6'b111111);

    // R3 immediate
    writeEn(6'b000001);
    setEv(6'b000001);
    check(status[0] == 1'b1, "R7 set", status[0], 1);
    check(irqOut == 1'b0, "R3 not yet", irqOut, 0);
    @(negedge clk);
    check(irqOut == 1'b1, "R3 immediate", irqOut, 1);
    clrEv(6'b000001);
    check(status[0] == 1'b0, "R8 cleared", status[0], 0);
    @(negedge clk);
    check(irqOut == 1'b0, "R9 fall", irqOut, 0);

    // R4 paced at 4
    writeThr(8'h04);
    setEv(6'b000001);
    tick(); tick(); tick();
    check(irqOut == 1'b0, "R4 before close", irqOut, 0);
    tick();
    check(irqOut == 1'b1, "R4 at close", irqOut, 1);
    // R10 hold through further ticks and events
    setEv(6'b000100); tick(); tick();
    check(irqOut == 1'b1, "R10 hold", irqOut, 1);

    // R7 set beats clear
    statusSet = 6'b000001; statusClrWr = 1; statusClrData = 6'b000001;
    @(negedge clk); clearIns();
    check(status[0] == 1'b1, "R7 set wins", status[0], 1);

    // R8 partial clear
    setEv(6'b001000);
    clrEv(6'b000001);
    check(status == 6'b001100, "R8 partial", status, 6'b001100);
    clrEv(6'b001100);
    @(negedge clk);
    check(irqOut == 1'b0, "R9 fall paced", irqOut, 0);

    // R9 re-arm waits for close; R6 restart with tick in write cycle
    thrWrEn = 1; thrWrData = 8'h02; mfTick = 1; @(negedge clk); clearIns();
    setEv(6'b000001);
    tick();
    check(irqOut == 1'b0, "R6 tick in write ignored", irqOut, 0);
    check(irqOut == 1'b0, "R9 waits", irqOut, 0);
    tick();
    check(irqOut == 1'b1, "R6 close after restart", irqOut, 1);
    clrEv(6'b000001);
    idle(2);

    // varied patterns: all codes with random events
    for (int k = 0; k < 8; k++) begin
      writeThr((k == 0) ? 8'h00 : 8'(1 << (k - 1)));
      writeEn(NS'($urandom));
      for (int c = 0; c < 300; c++) begin
        mfTick        = ($urandom % 3) == 0;
        statusSet     = (($urandom % 5) == 0) ? NS'($urandom) : '0;
        statusClrWr   = ($urandom % 6) == 0;
        statusClrData = NS'($urandom);
        enWr          = ($urandom % 40) == 0;
        enData        = NS'($urandom);
        thrWrEn       = ($urandom % 97) == 0;
        thrWrData     = 8'($urandom % 70);
        @(negedge clk);
      end
      clearIns();
    end
    idle(2);
    done = 1;
  end

  initial begin
    wait (done || cycles > 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected done", cycles);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule